// File: doc/BRIEF.md
# Prescaled Modulo Timer with Overflow Flag

This block is a 16-bit up-counter that advances on prescaled ticks of the input clock. It counts from zero up to a programmable modulo value and then returns to zero. That return is the overflow event. It sets a sticky overflow flag and can raise an interrupt request. Software reaches the block through a small synchronous register bus with a 3-bit address, a read strobe, a write strobe, 8-bit write data and combinational 8-bit read data.

The overflow flag is held by a three-state machine:

- `FLG_IDLE`: the flag is clear.
- `FLG_PEND`: the flag is set but not yet armed for clearing.
- `FLG_ARMED`: the flag is set and a read of the control register has seen it.

The transitions are named as follows:

- `ovf_set`: any state goes to `FLG_PEND` on an overflow. This has top priority.
- `arm_read`: `FLG_PEND` goes to `FLG_ARMED` on a control-register read.
- `clear_write`: `FLG_ARMED` goes to `FLG_IDLE` on a control write with bit 7 = 0.
- `disarm_write`: `FLG_ARMED` goes to `FLG_PEND` on a control write with bit 7 = 1.
- `hold`: a state stays as it is in every other case.

Because an overflow always forces `FLG_PEND`, a clearing write that follows an overflow has nothing to clear. No interrupt is lost.

Register map (address : content):

| Address | Content |
|---|---|
| 0 | Control/status |
| 1 | Modulo high byte |
| 2 | Modulo low byte |
| 3 | Counter high byte (read only) |
| 4 | Counter low byte (read only) |

Top module: `modtmr_top`

## Requirements
- R1: On each prescaled tick the counter increments, except when it equals the modulo value; then it becomes 0 on that tick. With modulo 0 every tick is an overflow and the count stays 0.
- R2: The overflow flag is bit 7 of the control register (address 0). It sets on the same clock edge at which the counter returns to 0 from the modulo value.
- R3: The flag clears only when a control write with bit 7 = 0 follows a control read that returned the flag as 1. A write of 0 with no such read leaves the flag set. Writing 1 to bit 7 never sets the flag.
- R4: An overflow after the arming read discards the arming, so the following write of 0 leaves the flag set. Any control write also discards the arming.
- R5: `irq` is 1 exactly when the enable bit (bit 6) is 1 and the flag is 1.
- R6: While the stop bit (bit 5) is 1, the counter and the prescaler hold their values. Reset sets the stop bit.
- R7: Writing 1 to bit 4 clears the counter and the prescaler at that clock edge. Bit 4 and bit 3 always read 0.
- R8: Bits 2:0 select a division of the clock by 2^n for n = 0..6; the value 7 divides by 64. From a cleared prescaler, the first tick comes 2^n cycles after counting starts.
- R9: The modulo value is written as a high byte (address 1) and a low byte (address 2) and resets to 0xFFFF. The counter reads back as a high byte (address 3) and a low byte (address 4).
- R10: After reset the control register reads 0x20, the counter reads 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| irq | output | 1 | Overflow interrupt request |

## Verification
A flag state machine stuck in or wrongly left `FLG_ARMED` shows up at the port on the very next control write. Either the flag clears with no read before it, or it clears after an overflow that came between the read and the write. Both cases are visible in bit 7 and on `irq` one cycle after the write. A counter or prescaler error shows in the counter bytes within one tick period: a wrong division, a missed wrap, or a count that moves while stopped. A flag set one edge early or late shows up in the same sample as the counter's return to zero.

// File: rtl/modtmr_pkg.sv
package modtmr_pkg;

    localparam int CNT_W  = 16;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int PS_W   = 3;
    // prescaler width covers the largest division 2^(2^PS_W - 2)
    localparam int PRE_W  = (1 << PS_W) - 2;
    localparam logic [PS_W-1:0] PS_MAX = PS_W'(PRE_W);

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODH = 3'd1;
    localparam logic [ADDR_W-1:0] A_MODL = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNTH = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNTL = 3'd4;

    typedef enum logic [1:0] {
        FLG_IDLE  = 2'd0,
        FLG_PEND  = 2'd1,
        FLG_ARMED = 2'd2
    } flag_st_e;

endpackage

// File: rtl/modtmr_prescale.sv
module modtmr_prescale
    import modtmr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            clr,
    input  logic [PS_W-1:0] sel,
    output logic            tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PS_W-1:0]  n_eff;
    logic [PRE_W-1:0] mask;

    // selections above the largest division saturate to it
    assign n_eff = (sel > PS_MAX) ? PS_MAX : sel;
    assign mask  = (PRE_W'(1) << n_eff) - PRE_W'(1);
    assign tick  = run && ((pre_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    // R6
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(pre_q));

endmodule

// File: rtl/modtmr_counter.sv
module modtmr_counter
    import modtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] modulo,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    logic [CNT_W-1:0] cnt_q;
    logic             at_top;

    assign at_top = (cnt_q == modulo);
    assign ovf    = tick && !clr && at_top;
    assign count  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= at_top ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // R1
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (count == '0));

    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(count));

    // R7
    cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

endmodule

// File: rtl/modtmr_flag_fsm.sv
module modtmr_flag_fsm
    import modtmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic rd_ctrl,
    input  logic wr_ctrl,
    input  logic wr_bit,
    output logic flag
);

    flag_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= FLG_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        if (ovf) begin
            st_d = FLG_PEND;
        end else begin
            unique case (st_q)
                FLG_IDLE: st_d = FLG_IDLE;
                FLG_PEND: begin
                    if (!wr_ctrl && rd_ctrl) begin
                        st_d = FLG_ARMED;
                    end
                end
                FLG_ARMED: begin
                    if (wr_ctrl) begin
                        st_d = wr_bit ? FLG_PEND : FLG_IDLE;
                    end
                end
                default: st_d = FLG_IDLE;
            endcase
        end
    end

    always_comb begin
        flag = (st_q != FLG_IDLE);
    end

    // R4
    ovf_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (st_q == FLG_PEND));

    // R3
    no_arm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FLG_PEND && wr_ctrl) |=> flag);

endmodule

// File: rtl/modtmr_top.sv
module modtmr_top
    import modtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic             ie_q;
    logic             stop_q;
    logic [PS_W-1:0]  ps_q;
    logic [CNT_W-1:0] mod_q;
    logic [CNT_W-1:0] count;
    logic             tick;
    logic             ovf;
    logic             flag;
    logic             wr_ctrl;
    logic             rd_ctrl;
    logic             cnt_clr;
    logic             unused_wbit3;

    assign wr_ctrl      = bus_wr && (bus_addr == A_CTRL);
    assign rd_ctrl      = bus_rd && (bus_addr == A_CTRL);
    assign cnt_clr      = wr_ctrl && bus_wdata[4];
    assign unused_wbit3 = bus_wdata[3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            stop_q <= 1'b1;
            ps_q   <= '0;
            mod_q  <= '1;
        end else if (bus_wr) begin
            unique case (bus_addr)
                A_CTRL: begin
                    ie_q   <= bus_wdata[6];
                    stop_q <= bus_wdata[5];
                    ps_q   <= bus_wdata[PS_W-1:0];
                end
                A_MODH: mod_q[CNT_W-1:DATA_W] <= bus_wdata;
                A_MODL: mod_q[DATA_W-1:0]     <= bus_wdata;
                default: ;
            endcase
        end
    end

    modtmr_prescale u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (!stop_q),
        .clr   (cnt_clr),
        .sel   (ps_q),
        .tick  (tick)
    );

    modtmr_counter u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .clr    (cnt_clr),
        .modulo (mod_q),
        .count  (count),
        .ovf    (ovf)
    );

    modtmr_flag_fsm u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovf     (ovf),
        .rd_ctrl (rd_ctrl),
        .wr_ctrl (wr_ctrl),
        .wr_bit  (bus_wdata[7]),
        .flag    (flag)
    );

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = {flag, ie_q, stop_q, 2'b00, ps_q};
            A_MODH:  bus_rdata = mod_q[CNT_W-1:DATA_W];
            A_MODL:  bus_rdata = mod_q[DATA_W-1:0];
            A_CNTH:  bus_rdata = count[CNT_W-1:DATA_W];
            A_CNTL:  bus_rdata = count[DATA_W-1:0];
            default: bus_rdata = '0;
        endcase
    end

    assign irq = ie_q && flag;

    // R2
    flag_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (flag && count == '0));

    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !bus_wdata[6]) |=> !irq);

endmodule

// File: tb/modtmr_top_tb_top.sv
`timescale 1ns/1ps
module modtmr_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    modtmr_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // vector: [23] write, [22:20] addr, [19:16] requirement, [15:8] data, [7:0] expected
    localparam int NV = 14;
    localparam logic [23:0] VEC [0:NV-1] = '{
        {1'b0, 3'd0, 4'd10, 8'h00, 8'h20},  // R10 control reset value
        {1'b0, 3'd1, 4'd9,  8'h00, 8'hFF},  // R9 modulo high reset
        {1'b0, 3'd2, 4'd9,  8'h00, 8'hFF},  // R9 modulo low reset
        {1'b0, 3'd3, 4'd10, 8'h00, 8'h00},  // R10 counter high
        {1'b0, 3'd4, 4'd10, 8'h00, 8'h00},  // R10 counter low
        {1'b1, 3'd1, 4'd9,  8'h12, 8'h00},
        {1'b1, 3'd2, 4'd9,  8'h34, 8'h00},
        {1'b0, 3'd1, 4'd9,  8'h00, 8'h12},  // R9
        {1'b0, 3'd2, 4'd9,  8'h00, 8'h34},  // R9
        {1'b1, 3'd0, 4'd7,  8'h5F, 8'h00},
        {1'b0, 3'd0, 4'd7,  8'h00, 8'h47},  // R7 bits 4 and 3 read 0
        {1'b1, 3'd0, 4'd3,  8'hB0, 8'h00},
        {1'b0, 3'd0, 4'd3,  8'h00, 8'h20},  // R3 writing 1 does not set flag
        {1'b0, 3'd4, 4'd7,  8'h00, 8'h00}   // R7 counter cleared
    };

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #0.5 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        bus_addr = a;
        #0.5 v = bus_rdata;
    endtask

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
    end

    initial begin
        logic [7:0] v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R10 irq", 16'(irq), 16'd0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][23]) begin
                wr(VEC[i][22:20], VEC[i][15:8]);
            end else begin
                rd(VEC[i][22:20], v);
                chk($sformatf("R%0d vector %0d", VEC[i][19:16], i), 16'(v), 16'(VEC[i][7:0]));
            end
        end

        // R1 R2: modulo 3, divide by 1
        wr(1, 8'h00); wr(2, 8'h03); wr(0, 8'h30); wr(0, 8'h00);
        peek(4, v); chk("R1 count 0", 16'(v), 16'd0);
        @(negedge clk); peek(4, v); chk("R1 count 1", 16'(v), 16'd1);
        @(negedge clk); peek(4, v); chk("R1 count 2", 16'(v), 16'd2);
        @(negedge clk); peek(4, v); chk("R1 count 3", 16'(v), 16'd3);
        peek(0, v); chk("R2 flag before wrap", 16'(v[7]), 16'd0);
        @(negedge clk); peek(4, v); chk("R1 wrap to 0", 16'(v), 16'd0);
        peek(0, v); chk("R2 flag at wrap", 16'(v[7]), 16'd1);
        chk("R5 irq masked", 16'(irq), 16'd0);

        // R3 write 0 without read; R5 enable
        wr(0, 8'h40);
        peek(0, v); chk("R3 unarmed write keeps flag", 16'(v[7]), 16'd1);
        chk("R5 irq asserted", 16'(irq), 16'd1);

        // R6 stop
        wr(0, 8'h60);
        peek(4, v);
        repeat (5) @(negedge clk);
        peek(4, v2); chk("R6 counter held", 16'(v2), 16'(v));

        // R3 two-step clear
        rd(0, v); chk("R3 arming read", 16'(v), 16'hE0);
        wr(0, 8'h60);
        peek(0, v); chk("R3 flag cleared", 16'(v), 16'h60);
        chk("R5 irq dropped", 16'(irq), 16'd0);

        // R4 overflow between read and write
        wr(0, 8'h40);
        for (int k = 0; k < 10; k++) begin
            peek(0, v);
            if (v[7]) break;
            @(negedge clk);
        end
        chk("R2 flag set while running", 16'(v[7]), 16'd1);
        rd(0, v);
        repeat (4) @(negedge clk);
        wr(0, 8'h40);
        peek(0, v); chk("R4 overflow voids clear", 16'(v[7]), 16'd1);
        chk("R4 irq kept", 16'(irq), 16'd1);

        // R4 any write discards arming
        wr(0, 8'h60);
        rd(0, v);
        wr(0, 8'hE0);
        wr(0, 8'h60);
        peek(0, v); chk("R4 write discards arming", 16'(v[7]), 16'd1);
        rd(0, v);
        wr(0, 8'h60);
        peek(0, v); chk("R3 clear after fresh read", 16'(v[7]), 16'd0);

        // R8 divide by 4
        wr(1, 8'hFF); wr(2, 8'hFF); wr(0, 8'h30); wr(0, 8'h02);
        repeat (15) @(negedge clk);
        peek(4, v); chk("R8 div4 before tick", 16'(v), 16'd3);
        @(negedge clk);
        peek(4, v); chk("R8 div4 tick", 16'(v), 16'd4);

        // R8 select 7 divides by 64
        wr(0, 8'h37); wr(0, 8'h07);
        repeat (191) @(negedge clk);
        peek(4, v); chk("R8 div64 before tick", 16'(v), 16'd2);
        @(negedge clk);
        peek(4, v); chk("R8 div64 tick", 16'(v), 16'd3);

        // R7 reset while running
        wr(0, 8'h10);
        peek(4, v); chk("R7 cleared while running", 16'(v), 16'd0);
        @(negedge clk);
        peek(4, v); chk("R7 counts on", 16'(v), 16'd1);

        // R1 modulo 0
        wr(0, 8'h30); wr(1, 8'h00); wr(2, 8'h00); wr(0, 8'h00);
        peek(0, v); chk("R1 mod0 no flag yet", 16'(v[7]), 16'd0);
        @(negedge clk);
        peek(0, v); chk("R1 mod0 overflow per tick", 16'(v[7]), 16'd1);
        peek(4, v); chk("R1 mod0 count stays 0", 16'(v), 16'd0);

        summary();
    end

endmodule